// File: doc/BRIEF.md
# Home-Node Probe Filter Directory

This block is the coherence directory at a memory's home node in a small multi-node system. It records which memory lines are held in any cache, in which sharing state, and which node owns each line. For every coherent request it works out whether other caches must be probed, and how. The probe can be skipped, sent to the one owning node, or sent to all nodes as an invalidation. The directory is inclusive. A line with no entry is uncached, so a request that misses sends no probe for the line it asked for. A miss allocates an entry, and that may displace a victim entry whose line must then be invalidated wherever it is cached.

Requests arrive on a valid/ready channel, one per cycle. Each carries:
- a kind: fetch, load, store or clean eviction;
- a line address, whose low log2(SETS) bits select the set and whose upper bits form the tag;
- the requester's node number.

Each request is answered exactly one cycle later. The answer gives:
- the probe action for the requested line, the node it targets, and whether data comes from memory or from the owner;
- the entry state and owner after the update;
- a second probe action, target node and line address for any displaced victim.

The read-modify-write of the tracking array completes within the accepting cycle. Back-to-back requests to the same set therefore always see each other's updates.

Top module: `pf_dir`

## Requirements
- R1: Request kind encoding is 0 fetch, 1 load, 2 store, 3 clean eviction. `req_ready` is high whenever reset is released. `rsp_valid` is high in exactly the cycle after each accepted request and low otherwise.
- R2: A fetch, load or store that finds no entry reports `rsp_hit`=0 and action 0 (none), with target 0. Data is sourced from memory (`rsp_from_owner`=0). The new entry is state EM (code 1) with the requester as owner.
- R3: Action codes are 0 none, 1 directed, 2 directed invalidate, 3 broadcast invalidate. On a hit in EM, a fetch or load gives action 1 and a store gives action 2. Both target the recorded owner, and data comes from the owner.
- R4: State codes are 0 I, 1 EM, 2 O, 3 S, 4 S1. On a hit in O, a fetch or load gives action 1 to the owner and a store gives action 3. Data comes from the owner.
- R5: On a hit in S or S1, a fetch or load gives action 0 and a store gives action 3. Data comes from memory. `rsp_target` is 0 for every action other than 1 and 2.
- R6: A fetch or load hit changes state as follows:
  - EM becomes S1 if the requester is the owner, otherwise O; the owner is kept.
  - S1 becomes S when the requester is not the owner.
  - O and S are unchanged.
- R7: Every store leaves the entry in EM with the requester as owner.
- R8: On allocation, the victim is the lowest-numbered invalid way of the set. If no way is invalid, the set's round-robin pointer chooses the victim. The pointer starts at way 0 after reset and advances by one, modulo WAYS, on every allocation in that set.
- R9: Victim action is 0 for an invalid victim, 3 for O or S, and 2 for S1 or EM; action 2 targets the victim's owner. `rsp_vic_addr` gives the victim line address when the victim action is nonzero; otherwise the victim target and address are 0.
- R10: A clean eviction from the owner of an EM line returns the entry to I, and a later request to that line misses. An eviction from another node, to a non-EM line, or to an absent line changes nothing and gives action 0. The response reports the resulting state (owner 0 when I).
- R11: A request accepted in the cycle after a request to the same set sees that request's update.
- R12: During reset `rsp_valid` is low, and after reset every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high |
| req_kind | input | 2 | Request kind code |
| req_addr | input | ADDR_W | Line address (set in low bits) |
| req_node | input | NODE_W | Requesting node |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Entry was found |
| rsp_action | output | 2 | Probe action for the requested line |
| rsp_target | output | NODE_W | Node for a directed action |
| rsp_from_owner | output | 1 | Data comes from the owning cache |
| rsp_state | output | 3 | Entry state after update |
| rsp_owner | output | NODE_W | Entry owner after update |
| rsp_vic_action | output | 2 | Probe action for the displaced line |
| rsp_vic_target | output | NODE_W | Owner targeted by a victim invalidate |
| rsp_vic_addr | output | ADDR_W | Displaced line address |

## Verification
The bench drives one line through every state transition with back-to-back requests, because a design that updated the array late would answer the second request from stale state. It fills a set and keeps missing in it. A pointer that skipped advancing on free-way allocations, or a wrong preference for invalid ways, shows up as the wrong victim address. It sends clean evictions from non-owners and to shared lines, which a careless design would wrongly invalidate. A long random run over a few hot sets and nodes then covers every combination of request kind and entry state.

// File: rtl/pf_pkg.sv
package pf_pkg;

  typedef enum logic [1:0] {K_FETCH, K_LOAD, K_STORE, K_EVICT} req_kind_e;
  typedef enum logic [2:0] {ST_I, ST_EM, ST_O, ST_S, ST_S1} dir_state_e;
  typedef enum logic [1:0] {PR_NONE, PR_DIRECT, PR_DIRECT_INV, PR_BCAST_INV} probe_e;

  // Probe for the requested line when the entry is present.
  function automatic probe_e hit_probe(req_kind_e k, dir_state_e s);
    probe_e p;
    p = PR_NONE;
    if (k != K_EVICT) begin
      case (s)
        ST_O:         p = (k == K_STORE) ? PR_BCAST_INV  : PR_DIRECT;
        ST_EM:        p = (k == K_STORE) ? PR_DIRECT_INV : PR_DIRECT;
        ST_S, ST_S1:  p = (k == K_STORE) ? PR_BCAST_INV  : PR_NONE;
        default:      p = PR_NONE;
      endcase
    end
    return p;
  endfunction

  // Probe needed to clear a displaced entry's line.
  function automatic probe_e victim_probe(dir_state_e s);
    case (s)
      ST_O, ST_S:   return PR_BCAST_INV;
      ST_S1, ST_EM: return PR_DIRECT_INV;
      default:      return PR_NONE;
    endcase
  endfunction

  function automatic logic names_owner(probe_e p);
    return (p == PR_DIRECT) || (p == PR_DIRECT_INV);
  endfunction

  // State after a hit; same_node means requester equals recorded owner.
  function automatic dir_state_e hit_next(req_kind_e k, dir_state_e s, logic same_node);
    dir_state_e n;
    n = s;
    case (k)
      K_STORE: n = ST_EM;
      K_EVICT: n = (s == ST_EM && same_node) ? ST_I : s;
      default: begin
        if (s == ST_EM)                n = same_node ? ST_S1 : ST_O;
        else if (s == ST_S1 && !same_node) n = ST_S;
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pf_way_match.sv
module pf_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 13,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
  input  logic [WAYS-1:0]            row_vld,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WIDX-1:0]            hit_way,
  output logic                       free_any,
  output logic [WIDX-1:0]            free_way
);
  // Descending scan so the lowest-numbered qualifying way wins.
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_vld[w] && row_tags[w] == tag) begin
        hit     = 1'b1;
        hit_way = w[WIDX-1:0];
      end
      if (!row_vld[w]) begin
        free_any = 1'b1;
        free_way = w[WIDX-1:0];
      end
    end
  end
endmodule

// File: rtl/pf_rr_ptr.sv
module pf_rr_ptr #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SIDX = $clog2(SETS),
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [SIDX-1:0] set_idx,
  output logic [WIDX-1:0] ptr
);
  logic [WIDX-1:0] ptrs [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptrs[g] <= '0;
      else if (adv && set_idx == SIDX'(g))
        ptrs[g] <= (ptrs[g] == WIDX'(WAYS - 1)) ? '0 : ptrs[g] + 1'b1;
    end
  end

  assign ptr = ptrs[set_idx];
endmodule

// File: rtl/pf_dir.sv
module pf_dir
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NODE_W = 3,
  parameter int SETS   = 8,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NODE_W-1:0] req_node,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_action,
  output logic [NODE_W-1:0] rsp_target,
  output logic              rsp_from_owner,
  output logic [2:0]        rsp_state,
  output logic [NODE_W-1:0] rsp_owner,
  output logic [1:0]        rsp_vic_action,
  output logic [NODE_W-1:0] rsp_vic_target,
  output logic [ADDR_W-1:0] rsp_vic_addr
);
  localparam int SIDX  = $clog2(SETS);
  localparam int WIDX  = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SIDX;

  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  dir_state_e        st_q  [SETS][WAYS];
  logic [NODE_W-1:0] own_q [SETS][WAYS];

  req_kind_e         kind_w;
  logic [SIDX-1:0]   set_w;
  logic [TAG_W-1:0]  tag_w;
  logic [WAYS-1:0][TAG_W-1:0] row_tags;
  logic [WAYS-1:0]   row_vld;

  // Named internal events, also watched by the checker.
  logic              fire_w, hit_w, alloc_w, free_any_w, write_w;
  logic [WIDX-1:0]   hit_way_w, free_way_w, rr_ptr_w, vic_way_w, tgt_way_w;
  logic [2:0]        old_state_w;
  logic [NODE_W-1:0] old_owner_w;
  dir_state_e        old_st, vic_st, new_st, res_st;
  logic [NODE_W-1:0] new_own, vic_own;
  logic [TAG_W-1:0]  vic_tag;
  probe_e            act_w, vact_w;

  assign req_ready = rst_n;
  assign fire_w    = req_valid && req_ready;
  assign kind_w    = req_kind_e'(req_kind);
  assign set_w     = req_addr[SIDX-1:0];
  assign tag_w     = req_addr[ADDR_W-1:SIDX];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_tags[w] = tag_q[set_w][w];
      row_vld[w]  = (st_q[set_w][w] != ST_I);
    end
  end

  pf_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .row_tags (row_tags),
    .row_vld  (row_vld),
    .tag      (tag_w),
    .hit      (hit_w),
    .hit_way  (hit_way_w),
    .free_any (free_any_w),
    .free_way (free_way_w)
  );

  pf_rr_ptr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (alloc_w),
    .set_idx (set_w),
    .ptr     (rr_ptr_w)
  );

  assign alloc_w   = fire_w && !hit_w && (kind_w != K_EVICT);
  assign vic_way_w = free_any_w ? free_way_w : rr_ptr_w;
  assign tgt_way_w = hit_w ? hit_way_w : vic_way_w;
  assign write_w   = fire_w && (hit_w || alloc_w);

  assign old_st      = st_q[set_w][hit_way_w];
  assign old_owner_w = own_q[set_w][hit_way_w];
  assign old_state_w = old_st;
  assign vic_st      = st_q[set_w][vic_way_w];
  assign vic_own     = own_q[set_w][vic_way_w];
  assign vic_tag     = tag_q[set_w][vic_way_w];

  always_comb begin
    if (hit_w) begin
      new_st  = hit_next(kind_w, old_st, req_node == old_owner_w);
      new_own = (kind_w == K_STORE) ? req_node : old_owner_w;
    end else begin
      new_st  = ST_EM;
      new_own = req_node;
    end
    res_st = (hit_w || alloc_w) ? new_st : ST_I;
    act_w  = hit_w ? hit_probe(kind_w, old_st) : PR_NONE;
    vact_w = alloc_w ? victim_probe(vic_st) : PR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= ST_I;
          tag_q[s][w] <= '0;
          own_q[s][w] <= '0;
        end
    end else if (write_w) begin
      tag_q[set_w][tgt_way_w] <= tag_w;
      st_q[set_w][tgt_way_w]  <= new_st;
      own_q[set_w][tgt_way_w] <= new_own;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_action     <= '0;
      rsp_target     <= '0;
      rsp_from_owner <= 1'b0;
      rsp_state      <= '0;
      rsp_owner      <= '0;
      rsp_vic_action <= '0;
      rsp_vic_target <= '0;
      rsp_vic_addr   <= '0;
    end else begin
      rsp_valid      <= fire_w;
      rsp_hit        <= hit_w;
      rsp_action     <= act_w;
      rsp_target     <= names_owner(act_w) ? old_owner_w : '0;
      rsp_from_owner <= hit_w && (kind_w != K_EVICT) && (old_st == ST_EM || old_st == ST_O);
      rsp_state      <= res_st;
      rsp_owner      <= (res_st == ST_I) ? '0 : new_own;
      rsp_vic_action <= vact_w;
      rsp_vic_target <= (vact_w == PR_DIRECT_INV) ? vic_own : '0;
      rsp_vic_addr   <= (vact_w != PR_NONE) ? {vic_tag, set_w} : '0;
    end
  end
endmodule

// File: rtl/pf_dir_chk.sv
module pf_dir_chk #(
  parameter int NODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        req_kind,
  input logic [NODE_W-1:0] req_node,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [1:0]        rsp_action,
  input logic [NODE_W-1:0] rsp_target,
  input logic [2:0]        rsp_state,
  input logic [NODE_W-1:0] rsp_owner,
  input logic [1:0]        rsp_vic_action,
  input logic              fire_w,
  input logic              hit_w,
  input logic [2:0]        old_state_w,
  input logic [NODE_W-1:0] old_owner_w
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) fire_w |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !fire_w |=> !rsp_valid); // R1
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_hit |-> rsp_action == 2'd0); // R2
  AST_EM_STORE_DIRECT_INV: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w && hit_w && req_kind == 2'd2 && old_state_w == 3'd1 |=> rsp_action == 2'd2 && rsp_target == $past(old_owner_w)); // R3
  AST_SHARED_READ_FILTERED: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w && hit_w && req_kind < 2'd2 && (old_state_w == 3'd3 || old_state_w == 3'd4) |=> rsp_action == 2'd0); // R5
  AST_STORE_LEAVES_EM: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w && req_kind == 2'd2 |=> rsp_state == 3'd1 && rsp_owner == $past(req_node)); // R7
  AST_VICTIM_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_vic_action != 2'd0 |-> !rsp_hit); // R9
endmodule

bind pf_dir pf_dir_chk #(.NODE_W(NODE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_kind       (req_kind),
  .req_node       (req_node),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_action     (rsp_action),
  .rsp_target     (rsp_target),
  .rsp_state      (rsp_state),
  .rsp_owner      (rsp_owner),
  .rsp_vic_action (rsp_vic_action),
  .fire_w         (fire_w),
  .hit_w          (hit_w),
  .old_state_w    (old_state_w),
  .old_owner_w    (old_owner_w)
);

// File: tb/pf_dir_tb.sv
module pf_dir_tb;
  localparam int ADDR_W = 16;
  localparam int NODE_W = 3;
  localparam int SETS   = 8;
  localparam int WAYS   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready;
  logic [1:0] req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [NODE_W-1:0] req_node;
  logic rsp_valid, rsp_hit, rsp_from_owner;
  logic [1:0] rsp_action, rsp_vic_action;
  logic [NODE_W-1:0] rsp_target, rsp_owner, rsp_vic_target;
  logic [2:0] rsp_state;
  logic [ADDR_W-1:0] rsp_vic_addr;

  pf_dir #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .SETS(SETS), .WAYS(WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_node(req_node),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_action(rsp_action),
    .rsp_target(rsp_target), .rsp_from_owner(rsp_from_owner), .rsp_state(rsp_state),
    .rsp_owner(rsp_owner), .rsp_vic_action(rsp_vic_action),
    .rsp_vic_target(rsp_vic_target), .rsp_vic_addr(rsp_vic_addr));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model: flat integer tables, state codes 0 I,1 EM,2 O,3 S,4 S1.
  int m_tag [SETS*WAYS];
  int m_st  [SETS*WAYS];
  int m_own [SETS*WAYS];
  int m_rr  [SETS];

  int e_valid, e_hit, e_act, e_tgt, e_src, e_st, e_own, e_vact, e_vtgt, e_vaddr;
  string e_req;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  function automatic void predict(int k, int addr, int node);
    int s = addr % SETS;
    int t = addr / SETS;
    int hw = -1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (m_st[s*WAYS+w] != 0 && m_tag[s*WAYS+w] == t) hw = w;
    e_valid = 1; e_hit = (hw >= 0);
    e_act = 0; e_tgt = 0; e_src = 0; e_vact = 0; e_vtgt = 0; e_vaddr = 0;
    if (k == 3) begin
      e_req = "R10";
      if (hw >= 0) begin
        int i = s*WAYS + hw;
        if (m_st[i] == 1 && m_own[i] == node) m_st[i] = 0;
        e_st = m_st[i];
        e_own = (m_st[i] == 0) ? 0 : m_own[i];
      end else begin
        e_st = 0; e_own = 0;
      end
    end else if (hw >= 0) begin
      int i = s*WAYS + hw;
      int os = m_st[i];
      int oo = m_own[i];
      if (k == 2) begin
        e_act = (os == 1) ? 2 : 3;
        m_st[i] = 1; m_own[i] = node;
        e_req = "R7";
      end else begin
        if (os == 1) begin e_act = 1; m_st[i] = (oo == node) ? 4 : 2; end
        else if (os == 2) e_act = 1;
        else if (os == 4 && oo != node) m_st[i] = 3;
        e_req = (os == 1) ? "R3" : (os == 2) ? "R4" : "R5";
      end
      e_tgt = (e_act == 1 || e_act == 2) ? oo : 0;
      e_src = (os == 1 || os == 2);
      e_st = m_st[i]; e_own = m_own[i];
    end else begin
      int vw = -1;
      int i;
      int vs;
      for (int w = WAYS - 1; w >= 0; w--)
        if (m_st[s*WAYS+w] == 0) vw = w;
      if (vw < 0) vw = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % WAYS;
      i = s*WAYS + vw;
      vs = m_st[i];
      e_vact = (vs == 0) ? 0 : (vs == 2 || vs == 3) ? 3 : 2;
      e_vtgt = (e_vact == 2) ? m_own[i] : 0;
      e_vaddr = (e_vact != 0) ? m_tag[i]*SETS + s : 0;
      m_tag[i] = t; m_st[i] = 1; m_own[i] = node;
      e_st = 1; e_own = node;
      e_req = (e_vact != 0) ? "R9" : "R2";
    end
  endfunction

  // One clock: drive at a falling edge, compare at the next falling edge.
  task automatic cyc(bit v, int k, int addr, int node);
    req_valid = v;
    req_kind  = k[1:0];
    req_addr  = addr[ADDR_W-1:0];
    req_node  = node[NODE_W-1:0];
    if (v) predict(k, addr, node);
    else begin e_valid = 0; e_req = "R1"; end
    @(negedge clk);
    chk("R1", "rsp_valid", int'(rsp_valid), e_valid);
    if (e_valid != 0) begin
      chk(e_req, "hit", int'(rsp_hit), e_hit);
      chk(e_req, "action", int'(rsp_action), e_act);
      chk(e_req, "target", int'(rsp_target), e_tgt);
      chk(e_req, "from_owner", int'(rsp_from_owner), e_src);
      chk((e_req == "R3" || e_req == "R5") ? "R6" : e_req, "state", int'(rsp_state), e_st);
      chk(e_req, "owner", int'(rsp_owner), e_own);
      chk("R9", "vic_action", int'(rsp_vic_action), e_vact);
      chk("R9", "vic_target", int'(rsp_vic_target), e_vtgt);
      chk("R8", "vic_addr", int'(rsp_vic_addr), e_vaddr);
    end
  endtask

  function automatic int ad(int tag, int set);
    return tag*SETS + set;
  endfunction

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_node = '0;
    for (int i = 0; i < SETS*WAYS; i++) begin m_tag[i] = 0; m_st[i] = 0; m_own[i] = 0; end
    for (int s = 0; s < SETS; s++) m_rr[s] = 0;
    repeat (3) @(negedge clk);
    chk("R12", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "req_ready", int'(req_ready), 1);

    // One line through every state, back to back in one set (R11, R6).
    cyc(1, 1, ad(1,0), 1);  // load miss -> EM owner 1 (R2)
    cyc(1, 1, ad(1,0), 1);  // EM hit same node -> directed, S1 (R3, R6)
    cyc(1, 1, ad(1,0), 2);  // S1 hit other node -> filtered, S (R5, R6)
    cyc(1, 2, ad(1,0), 3);  // store on S -> broadcast, EM owner 3 (R7)
    cyc(1, 1, ad(1,0), 4);  // EM other node -> directed to 3, O (R3, R6)
    cyc(1, 0, ad(1,0), 5);  // fetch on O -> directed to 3 (R4)
    cyc(1, 2, ad(1,0), 5);  // store on O -> broadcast, EM owner 5 (R4)
    cyc(1, 2, ad(1,0), 6);  // store on EM -> directed invalidate to 5 (R3)
    cyc(0, 0, 0, 0);        // idle: no response (R1)
    cyc(1, 3, ad(1,0), 2);  // eviction by non-owner ignored (R10)
    cyc(1, 3, ad(1,0), 6);  // eviction by owner -> I (R10)
    cyc(1, 1, ad(1,0), 1);  // now misses again (R10)
    cyc(1, 3, ad(9,0), 1);  // eviction of absent line: nothing (R10)

    // Fill set 1 with EM, O, S1, S lines, then displace each (R8, R9).
    cyc(1, 1, ad(1,1), 1);
    cyc(1, 1, ad(2,1), 2); cyc(1, 1, ad(2,1), 3);
    cyc(1, 1, ad(3,1), 3); cyc(1, 1, ad(3,1), 3);
    cyc(1, 1, ad(4,1), 4); cyc(1, 1, ad(4,1), 4); cyc(1, 0, ad(4,1), 5);
    cyc(1, 1, ad(5,1), 6);  // pointer at way 0: EM victim -> directed invalidate
    cyc(1, 1, ad(6,1), 6);  // way 1: O victim -> broadcast
    cyc(1, 2, ad(7,1), 6);  // way 2: S1 victim -> directed invalidate
    cyc(1, 0, ad(8,1), 6);  // way 3: S victim -> broadcast
    cyc(1, 3, ad(6,1), 6);  // free way 1
    cyc(1, 1, ad(9,1), 2);  // free way preferred over pointer (R8)
    cyc(1, 1, ad(10,1), 2); // pointer continues (R8)

    // Random traffic over two hot sets and four nodes (R11).
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) cyc(0, 0, 0, 0);
      else cyc(1, $urandom_range(0, 3), ad($urandom_range(0, 5), $urandom_range(0, 1)),
               $urandom_range(0, 3));
    end

    req_valid = 1'b0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule